// File: doc/BRIEF.md
# Two-Level Compressed Cache Tag Controller

This block keeps the tag state of one set of a compressed last-level cache. Every physical way owns a single 64-byte data slot that two tags share. The first tag of each way is the primary copy. Across the set, these primary tags behave exactly like an uncompressed cache of the same associativity, and a not-recently-used (NRU) policy replaces them. The second tag of each way holds clean lines that the primary level has displaced. It fills only when the compressed sizes leave room in the shared slot.

Each request carries an address tag, the line's current compressed size and a write flag. One cycle later the block answers with the following:
- where the request hit, if it hit;
- the way that now holds the line as a primary entry;
- any dirty line that must be written to memory;
- any clean line that was discarded from the secondary level;
- any displaced primary line that found no room at all.

The data array, the compression engines and memory are outside this block. Only tags, sizes, validity, dirtiness and replacement state are kept.

Top module: `bvc_ctrl`

## Requirements
- R1: After reset every primary and secondary entry is invalid and every NRU bit is 1. The first request after reset misses, lands in way 0, and reports no writeback, no discard and no loss.
- R2: A request whose tag matches a valid primary entry reports a primary hit in that entry's way. It reports no writeback, no replacement discard and no loss.
- R3: The allocation way is the lowest-numbered way whose NRU bit is 1. Any primary hit or fill clears that way's bit. If clearing the bit would leave all bits 0, every other bit is set to 1.
- R4: A request that matches nothing allocates a primary entry in the NRU way. The entry takes the request's tag and size, and it is dirty exactly when the request is a write.
- R5: When a primary allocation makes the new size plus the partner secondary size in that way exceed 64, the partner is invalidated and reported on the partner-discard output with its tag. A total of exactly 64 keeps the partner.
- R6: When a displaced primary line is dirty, the writeback output reports its tag in the same response. A clean displaced line causes no writeback.
- R7: A displaced primary line moves to the secondary level of the lowest-numbered way whose secondary slot is empty and whose free space covers the line's size. Free space is 64 minus that way's primary size, taking an invalid primary as 0. Equality fits.
- R8: When no empty secondary slot fits, the oldest-inserted occupied secondary entry that fits is replaced and reported on the replacement-discard output. When nothing fits, the displaced line is reported on the loss output instead, after any writeback.
- R9: A request that matches a secondary entry reports a secondary hit. That entry is freed, and the line then follows the R4 allocation path (NRU way, partner check, displacement), so a repeat request hits as primary in the reported way.
- R10: On a primary hit, the stored size becomes the request's size, and a write marks the entry dirty. If the new size no longer fits beside the partner, the partner is discarded as in R5.
- R11: Each request cycle produces exactly one response, one cycle later. A cycle without a request produces none.
- R12: A tag is present in at most one place in the set, and within every way the valid primary and secondary sizes sum to at most 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_tag | input | 16 | Address tag of the request |
| req_size | input | 7 | Compressed size of the line, 1 to 64 bytes |
| req_write | input | 1 | Request writes (dirties) the line |
| rsp_valid | output | 1 | Response present |
| rsp_hit0 | output | 1 | Hit in a primary entry |
| rsp_hit1 | output | 1 | Hit in a secondary entry |
| rsp_way | output | WW | Way that now holds the line as primary |
| wb_valid | output | 1 | Dirty displaced line must be written back |
| wb_tag | output | 16 | Tag of that line (0 when not valid) |
| pdrop_valid | output | 1 | Partner secondary line discarded for space |
| pdrop_tag | output | 16 | Tag of that line |
| rdrop_valid | output | 1 | Secondary line replaced by a newer victim |
| rdrop_tag | output | 16 | Tag of that line |
| lost_valid | output | 1 | Displaced primary line found no secondary room |
| lost_tag | output | 16 | Tag of that line |

## Verification
The assertions take for granted that every request carries a size between 1 and 64 bytes. They also assume that requests never hold the same tag in two places at once, which the block itself maintains as long as lines enter only through its own allocation path. The stimulus keeps all sizes inside that range. It builds every situation from an empty set through ordinary requests, so no state is ever forced. The sequence walks the NRU rollover, a swap from the secondary level back to the primary, and size ties at exactly 64 bytes. Each expected response is worked out by hand from the requirements before the corresponding request is sent.

// File: rtl/bvc_pkg.sv
package bvc_pkg;

    localparam int SLOT_BYTES = 64;
    localparam int SIZE_W     = $clog2(SLOT_BYTES + 1);
    localparam int TAG_W      = 16;

    typedef logic [SIZE_W-1:0] size_t;
    typedef logic [TAG_W-1:0]  tag_t;

    typedef struct packed {
        logic  vld;
        logic  dirty;
        tag_t  tag;
        size_t size;
    } prim_ent_t;

    typedef struct packed {
        logic  vld;
        tag_t  tag;
        size_t size;
    } sec_ent_t;

    localparam logic [SIZE_W:0] SLOT_WIDE = SLOT_BYTES;

    function automatic logic pair_fits(size_t a, size_t b);
        return ({1'b0, a} + {1'b0, b}) <= SLOT_WIDE;
    endfunction

    function automatic size_t free_bytes(size_t used);
        return size_t'(SLOT_BYTES) - used;
    endfunction

endpackage

// File: rtl/bvc_match.sv
module bvc_match
    import bvc_pkg::*;
#(
    parameter int WAYS = 4,
    localparam int WW = $clog2(WAYS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [WAYS-1:0]            p_vld,
    input  logic [WAYS-1:0][TAG_W-1:0] p_tag,
    input  logic [WAYS-1:0]            s_vld,
    input  logic [WAYS-1:0][TAG_W-1:0] s_tag,
    input  tag_t                       key,
    output logic [WAYS-1:0]            hit_p,
    output logic [WAYS-1:0]            hit_s,
    output logic [WW-1:0]              way_p,
    output logic [WW-1:0]              way_s
);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_p[w] = p_vld[w] && (p_tag[w] == key);
        assign hit_s[w] = s_vld[w] && (s_tag[w] == key);
    end

    always_comb begin
        way_p = '0;
        way_s = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_p[w]) way_p = WW'(w);
            if (hit_s[w]) way_s = WW'(w);
        end
    end

    // a tag lives in one place only
    p_unique_tag_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hit_p, hit_s}));

endmodule

// File: rtl/bvc_nru.sv
module bvc_nru #(
    parameter int WAYS = 4,
    localparam int WW = $clog2(WAYS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          touch,
    input  logic [WW-1:0] touch_way,
    output logic [WW-1:0] pick_way
);

    logic [WAYS-1:0] age_q, age_d, sel;

    assign sel = {{(WAYS-1){1'b0}}, 1'b1} << touch_way;

    always_comb begin
        age_d = age_q & ~sel;
        if (age_d == '0) age_d = ~sel;
    end

    always_comb begin
        pick_way = '0;
        for (int w = WAYS - 1; w >= 0; w--)
            if (age_q[w]) pick_way = WW'(w);
    end

    always_ff @(posedge clk) begin
        if (rst)        age_q <= '1;
        else if (touch) age_q <= age_d;
    end

    p_nru_live_r3: assert property (@(posedge clk) disable iff (rst)
        age_q != '0);

    p_nru_touch_r3: assert property (@(posedge clk) disable iff (rst)
        touch |=> !age_q[$past(touch_way)]);

endmodule

// File: rtl/bvc_place.sv
module bvc_place
    import bvc_pkg::*;
#(
    parameter int WAYS = 4,
    parameter int AW = 4,
    localparam int WW = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][SIZE_W-1:0] used,
    input  logic [WAYS-1:0]             occ,
    input  logic [WAYS-1:0][AW-1:0]     ins_age,
    input  size_t                       vsize,
    output logic                        place_ok,
    output logic [WW-1:0]               place_way
);

    logic          fit_w, got_e, got_o;
    logic [WW-1:0] e_way, o_way;
    logic [AW-1:0] best;

    always_comb begin
        got_e = 1'b0;
        got_o = 1'b0;
        e_way = '0;
        o_way = '0;
        best  = '0;
        fit_w = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            fit_w = free_bytes(used[w]) >= vsize;
            if (fit_w && !occ[w] && !got_e) begin
                got_e = 1'b1;
                e_way = WW'(w);
            end
            if (fit_w && occ[w] && (!got_o || ins_age[w] > best)) begin
                got_o = 1'b1;
                o_way = WW'(w);
                best  = ins_age[w];
            end
        end
        place_ok  = got_e | got_o;
        place_way = got_e ? e_way : o_way;
    end

endmodule

// File: rtl/bvc_ctrl.sv
module bvc_ctrl
    import bvc_pkg::*;
#(
    parameter int WAYS = 4,
    localparam int WW = $clog2(WAYS),
    localparam int AW = WW + 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [15:0]   req_tag,
    input  logic [6:0]    req_size,
    input  logic          req_write,
    output logic          rsp_valid,
    output logic          rsp_hit0,
    output logic          rsp_hit1,
    output logic [WW-1:0] rsp_way,
    output logic          wb_valid,
    output logic [15:0]   wb_tag,
    output logic          pdrop_valid,
    output logic [15:0]   pdrop_tag,
    output logic          rdrop_valid,
    output logic [15:0]   rdrop_tag,
    output logic          lost_valid,
    output logic [15:0]   lost_tag
);

    prim_ent_t prim_q [WAYS];
    prim_ent_t prim_n [WAYS];
    sec_ent_t  sec_q  [WAYS];
    sec_ent_t  sec_n  [WAYS];
    sec_ent_t  sec_f  [WAYS];
    logic [WAYS-1:0][AW-1:0] age_q, age_n;

    logic [WAYS-1:0]             p_vld, s_vld, hit_p, hit_s, occ_n;
    logic [WAYS-1:0][TAG_W-1:0]  p_tag, s_tag;
    logic [WAYS-1:0][SIZE_W-1:0] used_n;
    logic [WW-1:0]               way_p, way_s, nru_way, place_way;
    logic                        any_p, any_s, place_ok;
    prim_ent_t                   vic;

    logic n_wb, n_pd, n_rd, n_lost;
    tag_t n_wb_tag, n_pd_tag, n_rd_tag, n_lost_tag;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            p_vld[w]  = prim_q[w].vld;
            p_tag[w]  = prim_q[w].tag;
            s_vld[w]  = sec_q[w].vld;
            s_tag[w]  = sec_q[w].tag;
            occ_n[w]  = sec_n[w].vld;
            used_n[w] = prim_n[w].vld ? prim_n[w].size : '0;
        end
    end

    bvc_match #(.WAYS(WAYS)) u_match (
        .clk(clk), .rst(rst), .p_vld(p_vld), .p_tag(p_tag),
        .s_vld(s_vld), .s_tag(s_tag), .key(req_tag),
        .hit_p(hit_p), .hit_s(hit_s), .way_p(way_p), .way_s(way_s)
    );

    assign any_p = |hit_p;
    assign any_s = |hit_s;

    bvc_nru #(.WAYS(WAYS)) u_nru (
        .clk(clk), .rst(rst), .touch(req_valid),
        .touch_way(any_p ? way_p : nru_way), .pick_way(nru_way)
    );

    // stage 1: primary update, partner check, freeing a secondary hit
    always_comb begin
        prim_n   = prim_q;
        sec_n    = sec_q;
        vic      = '0;
        n_wb     = 1'b0;
        n_wb_tag = '0;
        n_pd     = 1'b0;
        n_pd_tag = '0;
        if (req_valid) begin
            if (any_p) begin
                prim_n[way_p].size  = req_size;
                prim_n[way_p].dirty = prim_q[way_p].dirty | req_write;
                if (sec_q[way_p].vld && !pair_fits(req_size, sec_q[way_p].size)) begin
                    n_pd     = 1'b1;
                    n_pd_tag = sec_q[way_p].tag;
                    sec_n[way_p].vld = 1'b0;
                end
            end else begin
                if (any_s) sec_n[way_s].vld = 1'b0;
                vic = prim_q[nru_way];
                if (vic.vld && vic.dirty) begin
                    n_wb     = 1'b1;
                    n_wb_tag = vic.tag;
                end
                if (sec_n[nru_way].vld && !pair_fits(req_size, sec_n[nru_way].size)) begin
                    n_pd     = 1'b1;
                    n_pd_tag = sec_n[nru_way].tag;
                    sec_n[nru_way].vld = 1'b0;
                end
                prim_n[nru_way] = '{vld: 1'b1, dirty: req_write, tag: req_tag, size: req_size};
            end
        end
    end

    bvc_place #(.WAYS(WAYS), .AW(AW)) u_place (
        .used(used_n), .occ(occ_n), .ins_age(age_q), .vsize(vic.size),
        .place_ok(place_ok), .place_way(place_way)
    );

    // stage 2: park the displaced primary line
    always_comb begin
        sec_f      = sec_n;
        age_n      = age_q;
        n_rd       = 1'b0;
        n_rd_tag   = '0;
        n_lost     = 1'b0;
        n_lost_tag = '0;
        if (vic.vld) begin
            if (place_ok) begin
                if (sec_n[place_way].vld) begin
                    n_rd     = 1'b1;
                    n_rd_tag = sec_n[place_way].tag;
                end
                sec_f[place_way] = '{vld: 1'b1, tag: vic.tag, size: vic.size};
                for (int w = 0; w < WAYS; w++)
                    if (sec_f[w].vld && age_q[w] != '1) age_n[w] = age_q[w] + 1'b1;
                age_n[place_way] = '0;
            end else begin
                n_lost     = 1'b1;
                n_lost_tag = vic.tag;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WAYS; w++) begin
                prim_q[w] <= '0;
                sec_q[w]  <= '0;
            end
            age_q       <= '0;
            rsp_valid   <= 1'b0;
            rsp_hit0    <= 1'b0;
            rsp_hit1    <= 1'b0;
            rsp_way     <= '0;
            wb_valid    <= 1'b0;
            wb_tag      <= '0;
            pdrop_valid <= 1'b0;
            pdrop_tag   <= '0;
            rdrop_valid <= 1'b0;
            rdrop_tag   <= '0;
            lost_valid  <= 1'b0;
            lost_tag    <= '0;
        end else begin
            prim_q      <= prim_n;
            sec_q       <= sec_f;
            age_q       <= age_n;
            rsp_valid   <= req_valid;
            rsp_hit0    <= req_valid & any_p;
            rsp_hit1    <= req_valid & ~any_p & any_s;
            rsp_way     <= any_p ? way_p : nru_way;
            wb_valid    <= n_wb;
            wb_tag      <= n_wb_tag;
            pdrop_valid <= n_pd;
            pdrop_tag   <= n_pd_tag;
            rdrop_valid <= n_rd;
            rdrop_tag   <= n_rd_tag;
            lost_valid  <= n_lost;
            lost_tag    <= n_lost_tag;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_chk
        p_slot_fit_r12: assert property (@(posedge clk) disable iff (rst)
            (prim_q[w].vld && sec_q[w].vld) |->
                (({1'b0, prim_q[w].size} + {1'b0, sec_q[w].size}) <= SLOT_WIDE));
    end

    p_resp_r11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    p_hit_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_hit0 |-> !(wb_valid || rdrop_valid || lost_valid || rsp_hit1));

    p_lost_excl_r8: assert property (@(posedge clk) disable iff (rst)
        lost_valid |-> !rdrop_valid);

endmodule

// File: tb/sim_bvc_ctrl.sv
`timescale 1ns/1ps
module sim_bvc_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_tag = '0;
    logic [6:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid, rsp_hit0, rsp_hit1;
    logic [1:0]  rsp_way;
    logic        wb_valid, pdrop_valid, rdrop_valid, lost_valid;
    logic [15:0] wb_tag, pdrop_tag, rdrop_tag, lost_tag;

    always #2.5 clk = ~clk;

    bvc_ctrl #(.WAYS(4)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_tag(req_tag),
        .req_size(req_size), .req_write(req_write), .rsp_valid(rsp_valid),
        .rsp_hit0(rsp_hit0), .rsp_hit1(rsp_hit1), .rsp_way(rsp_way),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .pdrop_valid(pdrop_valid),
        .pdrop_tag(pdrop_tag), .rdrop_valid(rdrop_valid), .rdrop_tag(rdrop_tag),
        .lost_valid(lost_valid), .lost_tag(lost_tag)
    );

    typedef struct {
        logic        h0, h1;
        logic [1:0]  way;
        logic        wb;  logic [15:0] wbt;
        logic        pd;  logic [15:0] pdt;
        logic        rd;  logic [15:0] rdt;
        logic        ls;  logic [15:0] lst;
        string       req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    localparam logic [15:0] TA = 16'd1, TB = 16'd2, TC = 16'd3, TD = 16'd4,
                            TE = 16'd5, TF = 16'd6, TG = 16'd7, TH = 16'd8,
                            TI = 16'd9, TJ = 16'd10, TK = 16'd11, TL = 16'd12,
                            TM = 16'd13;

    task automatic send(input logic [15:0] t, input logic [6:0] s, input logic w,
                        input logic h0, input logic h1, input logic [1:0] way,
                        input logic wb, input logic [15:0] wbt,
                        input logic pd, input logic [15:0] pdt,
                        input logic rd, input logic [15:0] rdt,
                        input logic ls, input logic [15:0] lst, input string rq);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_tag = t; req_size = s; req_write = w;
        e = '{h0: h0, h1: h1, way: way, wb: wb, wbt: wbt, pd: pd, pdt: pdt,
              rd: rd, rdt: rdt, ls: ls, lst: lst, req: rq};
        q.push_back(e);
    endtask

    function automatic bit tag_ok(logic v_a, logic [15:0] t_a, logic v_e, logic [15:0] t_e);
        return (v_a == v_e) && (!v_e || t_a == t_e);
    endfunction

    always @(negedge clk) begin
        if (!rst && rsp_valid && !done) begin
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R11: response with no request, got valid=1 expected 0");
            end else begin
                exp_t e;
                e = q.pop_front();
                if (rsp_hit0 !== e.h0 || rsp_hit1 !== e.h1 || rsp_way !== e.way ||
                    !tag_ok(wb_valid, wb_tag, e.wb, e.wbt) ||
                    !tag_ok(pdrop_valid, pdrop_tag, e.pd, e.pdt) ||
                    !tag_ok(rdrop_valid, rdrop_tag, e.rd, e.rdt) ||
                    !tag_ok(lost_valid, lost_tag, e.ls, e.lst)) begin
                    errors++;
                    $display("FAIL %s: got h0=%0b h1=%0b way=%0d wb=%0b/%0d pd=%0b/%0d rd=%0b/%0d lost=%0b/%0d expected h0=%0b h1=%0b way=%0d wb=%0b/%0d pd=%0b/%0d rd=%0b/%0d lost=%0b/%0d",
                        e.req, rsp_hit0, rsp_hit1, rsp_way, wb_valid, wb_tag,
                        pdrop_valid, pdrop_tag, rdrop_valid, rdrop_tag, lost_valid, lost_tag,
                        e.h0, e.h1, e.way, e.wb, e.wbt, e.pd, e.pdt, e.rd, e.rdt, e.ls, e.lst);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got no completion, expected end of sequence");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || wb_valid !== 1'b0 || lost_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: reset outputs got rsp=%0b wb=%0b lost=%0b expected 0 0 0",
                     rsp_valid, wb_valid, lost_valid);
        end
        rst = 1'b0;
        //    tag sz  w  h0 h1 way wb     pd     rd     lost
        send(TA, 40, 0, 0, 0, 0, 0, 0,  0, 0,  0, 0,  0, 0,  "R1 R4 first miss");
        send(TB, 30, 1, 0, 0, 1, 0, 0,  0, 0,  0, 0,  0, 0,  "R4 write miss");
        send(TC, 20, 0, 0, 0, 2, 0, 0,  0, 0,  0, 0,  0, 0,  "R3 order");
        send(TD, 50, 0, 0, 0, 3, 0, 0,  0, 0,  0, 0,  0, 0,  "R3 rollover");
        send(TA, 40, 0, 1, 0, 0, 0, 0,  0, 0,  0, 0,  0, 0,  "R2 primary hit");
        send(TE, 24, 0, 0, 0, 1, 1, TB, 0, 0,  0, 0,  0, 0,  "R6 R7 dirty victim");
        send(TF, 48, 0, 0, 0, 2, 0, 0,  0, 0,  0, 0,  0, 0,  "R7 clean victim");
        send(TG, 50, 0, 0, 0, 0, 0, 0,  1, TC, 1, TB, 0, 0,  "R5 R8 partner and replace");
        send(TA, 40, 0, 0, 1, 1, 0, 0,  0, 0,  0, 0,  0, 0,  "R9 secondary hit");
        send(TA, 40, 0, 1, 0, 1, 0, 0,  0, 0,  0, 0,  0, 0,  "R9 now primary");
        send(TH, 64, 1, 0, 0, 3, 0, 0,  0, 0,  0, 0,  1, TD, "R8 no room");
        send(TA, 60, 1, 1, 0, 1, 0, 0,  1, TE, 0, 0,  0, 0,  "R10 resize write hit");
        send(TI, 10, 0, 0, 0, 0, 0, 0,  0, 0,  0, 0,  0, 0,  "R3 R7 victim own way");
        send(TJ, 8,  0, 0, 0, 2, 0, 0,  0, 0,  0, 0,  0, 0,  "R7 skip occupied");
        send(TK, 30, 0, 0, 0, 0, 0, 0,  1, TG, 0, 0,  0, 0,  "R5 partner overflow");
        send(TL, 20, 0, 0, 0, 1, 1, TA, 0, 0,  0, 0,  1, TA, "R6 R8 writeback then loss");
        send(TH, 64, 0, 1, 0, 3, 0, 0,  0, 0,  0, 0,  0, 0,  "R2 incompressible hit");
        send(TF, 48, 0, 0, 1, 0, 0, 0,  0, 0,  0, 0,  0, 0,  "R9 move other way");
        send(TM, 34, 0, 0, 0, 1, 0, 0,  0, 0,  0, 0,  0, 0,  "R5 exact 64 kept");
        send(TF, 48, 0, 1, 0, 0, 0, 0,  0, 0,  0, 0,  0, 0,  "R12 single copy");
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R11: idle response got %0b expected 0", rsp_valid);
        end
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R11: missing responses got %0d pending expected 0", q.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule